// File: doc/BRIEF.md
# PWM sequence value decoder

The decoder sits between a sequence memory and a four-channel pulse generator. A playback controller loads a base address and a sequence length, then issues advance requests. On each request the decoder fetches one, two or four 16-bit half-words from memory, distributes them over the four channel compare values (and, in one mode, the counter top value), and reports the number of half-words it consumed.

A 2-bit load mode selects how the half-words are used. The sequence length is counted in half-words, not in steps. A step that would read past the end of the sequence is not fetched; instead, the decoder flags the end of the sequence. Reads use a request/valid handshake. The decoder keeps the address of the next half-word across steps.

Top module: `pwm_seq_decoder`

## Requirements
- R1: After reset all compare values are 0, the counter top equals parameter TOP_RST, all four idle flags are 1, and mem_req_o, step_done_o and seq_end_o are 0.
- R2: Load mode 0 (common) fetches one half-word per step and drives it to all four compare values.
- R3: Load mode 1 (grouped) fetches two half-words per step: the first goes to channels 0 and 1, the second to channels 2 and 3.
- R4: Load mode 2 (individual) fetches four half-words per step and drives them to channels 0, 1, 2 and 3 in fetch order.
- R5: Load mode 3 (waveform) fetches four half-words per step. The first three go to channels 0 to 2, and bits 14:0 of the fourth become the counter top. Channel 3 keeps its previous compare value and its idle flag (bit 3 of chan_idle_o) is 1. Any other mode clears all idle flags on its step.
- R6: The length is counted in half-words. If the half-words consumed since start plus those the step needs exceed the length, the step makes no memory request, leaves all outputs unchanged, and seq_end_o pulses for one cycle.
- R7: mem_req_o stays high with a stable mem_addr_o until mem_valid_i. Each accepted half-word advances the address by one, so successive steps read consecutive addresses.
- R8: An advance request that arrives while a fetch is in progress is ignored. The load mode is captured when a step is accepted, so a later change of load_mode_i does not affect that step.
- R9: Each accepted step produces exactly one step_done_o pulse. That pulse is in the same cycle as the new compare set and carries words_used_o equal to the step's half-word count.
- R10: start_i loads the base address and length, clears the consumed count, and abandons any fetch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load base address and length, restart the sequence |
| base_addr_i | input | AW | Address of the first half-word |
| seq_len_i | input | LW | Sequence length in half-words |
| load_mode_i | input | 2 | 0 common, 1 grouped, 2 individual, 3 waveform |
| step_i | input | 1 | Advance request from the playback controller |
| mem_req_o | output | 1 | Read request to sequence memory |
| mem_addr_o | output | AW | Read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 16 | Read data half-word |
| cmp_o | output | 4x16 | Compare values, channel 0 in the low slice |
| top_o | output | 15 | Counter top value |
| chan_idle_o | output | 4 | Per-channel flag: no compare source, drive idle level |
| step_done_o | output | 1 | One-cycle pulse: new compare set presented |
| words_used_o | output | 3 | Half-words consumed by the completed step |
| seq_end_o | output | 1 | One-cycle pulse: step would overrun the sequence |

## Verification
The hardest situation to reach is a partial overrun. In that case some half-words remain, but fewer than the step needs, and the decoder must refuse the whole step without issuing a single read. The stimulus uses grouped mode with an odd length so that one half-word is left over, then checks the read counter, the compare values and seq_end_o. A second step request is also timed to land while a four-word fetch is still waiting on memory, with the load mode changed at the same moment. The check confirms that only one step completes and that it completes in the mode that was captured.

// File: rtl/pwm_seqdec_pkg.sv
package pwm_seqdec_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned HW_W   = 16;

  typedef enum logic [1:0] {
    LOAD_COMMON  = 2'd0,
    LOAD_GROUPED = 2'd1,
    LOAD_INDIV   = 2'd2,
    LOAD_WAVE    = 2'd3
  } load_mode_e;

  function automatic logic [2:0] words_per_step(load_mode_e m);
    case (m)
      LOAD_COMMON:  return 3'd1;
      LOAD_GROUPED: return 3'd2;
      default:      return 3'd4;
    endcase
  endfunction

  // half-word slot feeding a channel in a given mode
  function automatic logic [1:0] src_slot(load_mode_e m, int unsigned ch);
    case (m)
      LOAD_COMMON:  return 2'd0;
      LOAD_GROUPED: return 2'(ch / 2);
      default:      return 2'(ch);
    endcase
  endfunction
endpackage

// File: rtl/pwm_seqdec_fetch.sv
module pwm_seqdec_fetch
  import pwm_seqdec_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 15
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [AW-1:0]                 base_addr_i,
  input  logic [LW-1:0]                 seq_len_i,
  input  load_mode_e                    mode_i,
  input  logic                          step_i,
  output logic                          mem_req_o,
  output logic [AW-1:0]                 mem_addr_o,
  input  logic                          mem_valid_i,
  input  logic [HW_W-1:0]               mem_data_i,
  output logic [NUM_CH-1:0][HW_W-1:0]   stage_o,
  output load_mode_e                    mode_o,
  output logic                          ready_o,
  output logic                          end_o
);
  localparam int unsigned CW = LW + 1;

  logic                        busy_q, ready_q, end_q;
  logic [AW-1:0]               addr_q;
  logic [LW-1:0]               cnt_q, len_q;
  logic [1:0]                  slot_q;
  logic [2:0]                  need_q, need;
  load_mode_e                  mode_q;
  logic [NUM_CH-1:0][HW_W-1:0] stage_q;
  logic [CW-1:0]               cnt_after;
  logic                        overrun, last_word;

  assign need      = words_per_step(mode_i);
  assign cnt_after = {1'b0, cnt_q} + CW'(need);
  assign overrun   = cnt_after > {1'b0, len_q};
  assign last_word = ({1'b0, slot_q} + 3'd1) == need_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      end_q   <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      slot_q  <= '0;
      need_q  <= '0;
      mode_q  <= LOAD_COMMON;
      stage_q <= '0;
    end else begin
      ready_q <= 1'b0;
      end_q   <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b0;
        addr_q <= base_addr_i;
        cnt_q  <= '0;
        len_q  <= seq_len_i;
      end else if (!busy_q) begin
        if (step_i) begin
          if (overrun) begin
            end_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            mode_q <= mode_i;
            need_q <= need;
            slot_q <= '0;
          end
        end
      end else if (mem_valid_i) begin
        stage_q[slot_q] <= mem_data_i;
        addr_q <= addr_q + AW'(1);
        cnt_q  <= cnt_q + LW'(1);
        slot_q <= slot_q + 2'd1;
        if (last_word) begin
          busy_q  <= 1'b0;
          ready_q <= 1'b1;
        end
      end
    end
  end

  assign mem_req_o  = busy_q;
  assign mem_addr_o = addr_q;
  assign stage_o    = stage_q;
  assign mode_o     = mode_q;
  assign ready_o    = ready_q;
  assign end_o      = end_q;

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i && !start_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_q);
  // R6
  end_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> !mem_req_o);
endmodule

// File: rtl/pwm_seqdec_spread.sv
module pwm_seqdec_spread
  import pwm_seqdec_pkg::*;
#(
  parameter logic [14:0] TOP_RST = 15'd1000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ready_i,
  input  load_mode_e                    mode_i,
  input  logic [NUM_CH-1:0][HW_W-1:0]   stage_i,
  output logic [NUM_CH-1:0][HW_W-1:0]   cmp_o,
  output logic [14:0]                   top_o,
  output logic [NUM_CH-1:0]             idle_o,
  output logic                          done_o,
  output logic [2:0]                    used_o
);
  localparam int unsigned LAST_CH = NUM_CH - 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    // in waveform mode the last channel has no compare source
    logic no_src;
    if (ch == LAST_CH) begin : g_last
      assign no_src = (mode_i == LOAD_WAVE);
    end else begin : g_other
      assign no_src = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_o[ch]  <= '0;
        idle_o[ch] <= 1'b1;
      end else if (ready_i) begin
        idle_o[ch] <= no_src;
        if (!no_src) cmp_o[ch] <= stage_i[src_slot(mode_i, ch)];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_o  <= TOP_RST;
      done_o <= 1'b0;
      used_o <= '0;
    end else begin
      done_o <= ready_i;
      if (ready_i) begin
        used_o <= words_per_step(mode_i);
        if (mode_i == LOAD_WAVE) top_o <= stage_i[LAST_CH][14:0];
      end
    end
  end

  // R5
  wave_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && mode_i == LOAD_WAVE) |=> ($stable(cmp_o[LAST_CH]) && idle_o[LAST_CH]));
  // R2
  common_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && mode_i == LOAD_COMMON) |=> (cmp_o[0] == cmp_o[3] && cmp_o[1] == cmp_o[2]));
endmodule

// File: rtl/pwm_seq_decoder.sv
module pwm_seq_decoder
  import pwm_seqdec_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned LW      = 15,
  parameter logic [14:0] TOP_RST = 15'd1000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [AW-1:0]               base_addr_i,
  input  logic [LW-1:0]               seq_len_i,
  input  logic [1:0]                  load_mode_i,
  input  logic                        step_i,
  output logic                        mem_req_o,
  output logic [AW-1:0]               mem_addr_o,
  input  logic                        mem_valid_i,
  input  logic [15:0]                 mem_data_i,
  output logic [3:0][15:0]            cmp_o,
  output logic [14:0]                 top_o,
  output logic [3:0]                  chan_idle_o,
  output logic                        step_done_o,
  output logic [2:0]                  words_used_o,
  output logic                        seq_end_o
);
  logic [NUM_CH-1:0][HW_W-1:0] stage;
  load_mode_e                  mode_cap;
  logic                        ready;

  pwm_seqdec_fetch #(.AW(AW), .LW(LW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .seq_len_i   (seq_len_i),
    .mode_i      (load_mode_e'(load_mode_i)),
    .step_i      (step_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .mem_data_i  (mem_data_i),
    .stage_o     (stage),
    .mode_o      (mode_cap),
    .ready_o     (ready),
    .end_o       (seq_end_o)
  );

  pwm_seqdec_spread #(.TOP_RST(TOP_RST)) u_spread (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready),
    .mode_i  (mode_cap),
    .stage_i (stage),
    .cmp_o   (cmp_o),
    .top_o   (top_o),
    .idle_o  (chan_idle_o),
    .done_o  (step_done_o),
    .used_o  (words_used_o)
  );

  // R9
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_done_o, seq_end_o}));
  // R9
  used_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> (words_used_o != 3'd0));
  // R8
  no_done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> !$past(mem_req_o, 2) || !$past(step_i) || $past(mem_req_o));
endmodule

// File: tb/pwm_seq_decoder_test.sv
module pwm_seq_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [14:0] TOP_RST = 15'd1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, step = 1'b0;
  logic [15:0] base = '0;
  logic [14:0] len = '0;
  logic [1:0] mode = '0;
  logic mem_req, mem_valid = 1'b0;
  logic [15:0] mem_addr, mem_data = '0;
  logic [3:0][15:0] cmp;
  logic [14:0] top;
  logic [3:0] idle;
  logic done, seq_end;
  logic [2:0] used;

  int checks = 0, failures = 0, reads = 0;
  bit saw_done, saw_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_seq_decoder #(.TOP_RST(TOP_RST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .seq_len_i(len), .load_mode_i(mode), .step_i(step),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_data_i(mem_data), .cmp_o(cmp), .top_o(top), .chan_idle_o(idle),
    .step_done_o(done), .words_used_o(used), .seq_end_o(seq_end)
  );

  function automatic logic [15:0] word_at(int a);
    logic [15:0] v = 16'(a * 257);
    return (a % 2 == 1) ? (v | 16'h8000) : v;
  endfunction

  // memory: one-cycle latency, one word per two cycles
  always @(posedge clk) begin
    if (mem_req && mem_valid) reads <= reads + 1;
    mem_valid <= mem_req && !mem_valid;
    mem_data  <= word_at(int'(mem_addr[5:0]));
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(int b, int l, int m);
    @(negedge clk);
    base = 16'(b); len = 15'(l); mode = 2'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_step();
    saw_done = 0; saw_end = 0;
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    for (int i = 0; i < 30 && !saw_done && !saw_end; i++) begin
      if (done) saw_done = 1;
      else if (seq_end) saw_end = 1;
      else @(negedge clk);
    end
  endtask

  task automatic test_reset();
    chk(cmp == '0, "R1 cmp", cmp, 0);
    chk(top == TOP_RST, "R1 top", top, TOP_RST);
    chk(idle == 4'hF, "R1 idle", idle, 4'hF);
    chk(!mem_req && !done && !seq_end, "R1 ctl", {mem_req, done, seq_end}, 0);
  endtask

  task automatic test_common();
    do_start(4, 3, 0);
    for (int s = 0; s < 3; s++) begin
      do_step();
      chk(saw_done, "R2 done", saw_done, 1);
      for (int c = 0; c < 4; c++)
        chk(cmp[c] == word_at(4 + s), "R2 cmp", cmp[c], word_at(4 + s));
      chk(used == 3'd1, "R9 used", used, 1);
      chk(idle == 4'h0, "R5 idle clear", idle, 0);
    end
    begin
      int r0 = reads;
      do_step();
      chk(saw_end && !saw_done, "R6 end common", saw_end, 1);
      chk(reads == r0, "R6 no read", reads, r0);
      chk(cmp[0] == word_at(6), "R6 hold", cmp[0], word_at(6));
    end
  endtask

  task automatic test_grouped();
    int r0;
    do_start(10, 5, 1);
    for (int s = 0; s < 2; s++) begin
      do_step();
      chk(saw_done && used == 3'd2, "R3 used", used, 2);
      chk(cmp[0] == word_at(10 + 2*s) && cmp[1] == word_at(10 + 2*s), "R3 g0", cmp[1], word_at(10 + 2*s));
      chk(cmp[2] == word_at(11 + 2*s) && cmp[3] == word_at(11 + 2*s), "R3 g1", cmp[3], word_at(11 + 2*s));
    end
    r0 = reads;
    do_step();
    chk(saw_end, "R6 partial overrun", saw_end, 1);
    chk(reads == r0, "R6 partial no read", reads, r0);
    chk(cmp[2] == word_at(13), "R6 partial hold", cmp[2], word_at(13));
  endtask

  task automatic test_indiv();
    do_start(20, 8, 2);
    for (int s = 0; s < 2; s++) begin
      do_step();
      chk(saw_done && used == 3'd4, "R4 used", used, 4);
      for (int c = 0; c < 4; c++)
        chk(cmp[c] == word_at(20 + 4*s + c), "R4 cmp/R7 addr", cmp[c], word_at(20 + 4*s + c));
    end
  endtask

  task automatic test_wave();
    do_start(30, 4, 3);
    do_step();
    chk(saw_done && used == 3'd4, "R5 used", used, 4);
    for (int c = 0; c < 3; c++)
      chk(cmp[c] == word_at(30 + c), "R5 cmp", cmp[c], word_at(30 + c));
    chk(top == word_at(33)[14:0], "R5 top", top, word_at(33)[14:0]);
    chk(cmp[3] == word_at(27), "R5 ch3 held", cmp[3], word_at(27));
    chk(idle == 4'b1000, "R5 idle", idle, 4'b1000);
    do_step();
    chk(saw_end, "R6 wave end", saw_end, 1);
  endtask

  task automatic test_busy();
    int r0, dones;
    do_start(40, 12, 2);
    r0 = reads;
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b1; mode = 2'd0;
    @(negedge clk); step = 1'b0;
    dones = 0;
    for (int i = 0; i < 30; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk(dones == 1, "R8 one step", dones, 1);
    chk(reads - r0 == 4, "R8 reads", reads - r0, 4);
    chk(cmp[3] == word_at(43), "R8 mode latched", cmp[3], word_at(43));
  endtask

  task automatic test_restart();
    do_start(50, 0, 0);
    do_step();
    chk(saw_end, "R6 zero length", saw_end, 1);
    do_start(50, 2, 2);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    @(negedge clk);
    do_start(56, 1, 0);
    do_step();
    chk(saw_done && cmp[0] == word_at(56), "R10 restart", cmp[0], word_at(56));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_common();
    test_grouped();
    test_indiv();
    test_wave();
    test_busy();
    test_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule